// File: doc/BRIEF.md
# Duplicate-Verified Serial Command Slave

This block is a synchronous serial slave that takes byte-wide commands from a host over a chip-select, serial clock and data-in interface, and returns status bytes on a data-out line. The serial lines are oversampled in the system clock domain. A polarity input decides which serial clock edge samples data and which edge shifts status out. Each complete byte pulls the busy output low for a fixed number of cycles. The opcode's upper nibble decides whether a command is one byte or two bytes long. An executed command produces a general strobe carrying its opcode and argument. Three kinds of command also produce decoded strobes with their own fields: power-down, per-channel volume and phrase selection.

A mode command can turn on duplicate entry. In that mode the host sends every command frame twice, and the frame executes only when the second copy is identical to the first. If the copies differ, neither copy executes and a sticky error output goes high. Only the error-clear command resets it. Error-clear is honoured after a single entry even in duplicate mode, so a host may send it once or twice. A status-read command loads either an external status byte or the error flag into the output shifter.

Top module: `dupcmd_slave`

## Requirements
- R1: When `edge_sel` is 1, `sdi` is sampled on falling `sck` edges and `sdo` advances on rising edges. When `edge_sel` is 0, the two edges swap roles. Bits go out MSB first.
- R2: A frame is two bytes (opcode, then argument) when the opcode's upper nibble is 0x0, 0x1, 0x3, 0x5, 0x7, 0xA or 0xD. For every other upper nibble the frame is one byte.
- R3: Each executed frame gives exactly one `cmd_stb` pulse, with `cmd_op` set to the opcode and `cmd_arg` set to the argument (0 for one-byte frames). At most one of the decoded strobes is active at a time.
- R4: `pdwn_stb` pulses only for the one-byte opcode 0x20.
- R5: For an opcode with upper nibble 0xA, `vol_stb` pulses, `vol_mask` equals opcode bits 3:0 and `vol_lvl` equals argument bits 4:0.
- R6: For an opcode with upper nibble 0x3, `phr_stb` pulses, `phr_chan` equals opcode bits 3:2 and `phr_idx` equals {opcode bits 1:0, argument}.
- R7: A status-read opcode has upper nibble 0xB. If opcode bit 0 is 0 it loads `stat_i`; if bit 0 is 1 it loads {7'b0, err}. The loaded byte is shifted out over the next 8 sample edges, and those edges do not assemble command bits.
- R8: Upper nibble 0x0 is the mode command, and argument bit 0 sets duplicate entry. In duplicate mode a frame executes only on its second, identical copy; the first copy gives no strobe.
- R9: In duplicate mode, a second copy that differs from the first sets `err` to 1 and executes neither copy. `err` stays 1 through later executed frames. The next frame starts a new pair.
- R10: Upper nibble 0x8 is error-clear. It executes on a single entry in any mode, sets `err` to 0 and discards a pending first copy. A repeated clear executes again.
- R11: `busy_n` goes low the cycle after a byte completes and stays low for `BUSY_CYC` cycles. Sample edges while it is low are ignored.
- R12: Deasserting `cs_n` before a byte is complete discards its bits.
- R13: In reset, `err` is 0, `busy_n` is 1, `sdo` is 0, duplicate mode is off and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial command data in |
| edge_sel | input | 1 | Edge polarity select |
| stat_i | input | 8 | External status byte |
| sdo | output | 1 | Serial status data out |
| busy_n | output | 1 | Low while a byte is being processed |
| err | output | 1 | Sticky duplicate-mismatch error |
| cmd_stb | output | 1 | Executed frame strobe |
| cmd_op | output | 8 | Opcode of executed frame |
| cmd_arg | output | 8 | Argument of executed frame |
| pdwn_stb | output | 1 | Power-down strobe |
| vol_stb | output | 1 | Channel volume strobe |
| vol_mask | output | 4 | Channel mask for volume |
| vol_lvl | output | 5 | Volume level |
| phr_stb | output | 1 | Phrase select strobe |
| phr_chan | output | 2 | Phrase channel |
| phr_idx | output | 10 | Phrase number |

## Verification
Every one of the 256 opcodes is sent once with duplicate entry off. The first half is sent with one edge polarity and the second half with the other. This separates errors in length decoding, field extraction and edge choice, because any length error desynchronises all the frames that follow. Duplicate-mode sequences then cover matching pairs, mismatching pairs, clears sent once and twice, and a clear placed between two copies. This distinguishes a sticky error from one that merely pulses, and pairing that restarts from pairing that carries over. Bits clocked during busy and bytes cut short by chip select are checked by sending a clean byte afterwards and confirming that it is decoded exactly.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] NIB_MODE = 4'h0;
  localparam logic [3:0] NIB_PHR  = 4'h3;
  localparam logic [3:0] NIB_CLR  = 4'h8;
  localparam logic [3:0] NIB_CVOL = 4'hA;
  localparam logic [3:0] NIB_STAT = 4'hB;
  localparam logic [7:0] OP_PDWN  = 8'h20;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] arg;
  } frame_t;

  // opcode upper nibbles that carry a second (argument) byte
  function automatic logic two_byte(input logic [3:0] hi);
    case (hi)
      4'h0, 4'h1, 4'h3, 4'h5, 4'h7, 4'hA, 4'hD: two_byte = 1'b1;
      default:                                  two_byte = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dcs_sync_edge.sv
module dcs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic sdi,
  input  logic cs_n,
  input  logic edge_sel,
  output logic smp_ev,
  output logic drv_ev,
  output logic sdi_s,
  output logic cs_act
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_c, sdi_c, csn_c;
  logic              sck_d;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_c <= '0;
      sdi_c <= '0;
      csn_c <= '1;
      sck_d <= 1'b0;
    end else begin
      sck_c <= {sck_c[STAGES-2:0], sck};
      sdi_c <= {sdi_c[STAGES-2:0], sdi};
      csn_c <= {csn_c[STAGES-2:0], cs_n};
      sck_d <= sck_c[TOP];
    end
  end

  assign rise   = sck_c[TOP] & ~sck_d;
  assign fall   = ~sck_c[TOP] & sck_d;
  assign cs_act = ~csn_c[TOP];
  assign sdi_s  = sdi_c[TOP];
  // R1: polarity picks which edge samples and which edge shifts out
  assign smp_ev = cs_act & (edge_sel ? fall : rise);
  assign drv_ev = cs_act & (edge_sel ? rise : fall);
endmodule

// File: rtl/dcs_shift.sv
module dcs_shift
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_ev,
  input  logic              drv_ev,
  input  logic              sdi_s,
  input  logic              cs_act,
  input  logic              hold,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_data,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              sdo
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] tx;
  logic [CW-1:0]     rd_left;
  logic              rd_ph;

  // command byte assembly
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (smp_ev && rd_left == '0 && !hold) begin
        sh <= {sh[BYTE_W-3:0], sdi_s};
        if (bit_cnt == CW'(BYTE_W - 1)) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          byte_q   <= {sh, sdi_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // status readout: shift only after a sample edge of the readout
  always_ff @(posedge clk) begin
    if (rst) begin
      tx      <= '0;
      rd_left <= '0;
      rd_ph   <= 1'b0;
    end else if (!cs_act) begin
      rd_left <= '0;
      rd_ph   <= 1'b0;
    end else if (ld) begin
      tx      <= ld_data;
      rd_left <= CW'(BYTE_W);
      rd_ph   <= 1'b0;
    end else if (smp_ev && rd_left != '0) begin
      rd_left <= rd_left - 1'b1;
      rd_ph   <= 1'b1;
    end else if (drv_ev && rd_ph) begin
      tx    <= {tx[BYTE_W-2:0], 1'b0};
      rd_ph <= 1'b0;
    end
  end

  assign sdo = tx[BYTE_W-1];

  p_cs_drop_r12: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (bit_cnt == '0));
  p_rd_nobyte_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_left != '0) |=> !byte_vld);
endmodule

// File: rtl/dcs_frame.sv
module dcs_frame
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic [BYTE_W-1:0] stat_i,
  output logic              cmd_stb,
  output logic [BYTE_W-1:0] cmd_op,
  output logic [BYTE_W-1:0] cmd_arg,
  output logic              pdwn_stb,
  output logic              vol_stb,
  output logic [3:0]        vol_mask,
  output logic [4:0]        vol_lvl,
  output logic              phr_stb,
  output logic [1:0]        phr_chan,
  output logic [9:0]        phr_idx,
  output logic              ld,
  output logic [BYTE_W-1:0] ld_data,
  output logic              err
);
  logic              idx_q, dup_q, have_first;
  logic [BYTE_W-1:0] op_hold;
  frame_t            first_q, cur;
  logic              done, is_clr, same, exec, mism;

  always_comb begin
    cur.op  = idx_q ? op_hold : byte_q;
    cur.arg = idx_q ? byte_q : '0;
    done    = byte_vld && (idx_q || !two_byte(byte_q[7:4]));
    is_clr  = (cur.op[7:4] == NIB_CLR);
    same    = (first_q == cur);
    exec    = done && (!dup_q || is_clr || (have_first && same));
    mism    = done && dup_q && !is_clr && have_first && !same;
  end

  // framing and duplicate pairing
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 1'b0;
      op_hold    <= '0;
      dup_q      <= 1'b0;
      have_first <= 1'b0;
      first_q    <= '0;
      err        <= 1'b0;
    end else begin
      if (byte_vld) begin
        idx_q <= !idx_q && two_byte(byte_q[7:4]);
        if (!idx_q) op_hold <= byte_q;
      end
      if (done && dup_q) begin
        if (is_clr) begin
          have_first <= 1'b0;
        end else if (!have_first) begin
          have_first <= 1'b1;
          first_q    <= cur;
        end else begin
          have_first <= 1'b0;
        end
      end
      if (exec && cur.op[7:4] == NIB_MODE) dup_q <= cur.arg[0];
      if (exec && is_clr)  err <= 1'b0;
      else if (mism)       err <= 1'b1;
    end
  end

  // registered command outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_stb  <= 1'b0;
      cmd_op   <= '0;
      cmd_arg  <= '0;
      pdwn_stb <= 1'b0;
      vol_stb  <= 1'b0;
      vol_mask <= '0;
      vol_lvl  <= '0;
      phr_stb  <= 1'b0;
      phr_chan <= '0;
      phr_idx  <= '0;
      ld       <= 1'b0;
      ld_data  <= '0;
    end else begin
      cmd_stb  <= exec;
      pdwn_stb <= exec && (cur.op == OP_PDWN);
      vol_stb  <= exec && (cur.op[7:4] == NIB_CVOL);
      phr_stb  <= exec && (cur.op[7:4] == NIB_PHR);
      ld       <= exec && (cur.op[7:4] == NIB_STAT);
      if (exec) begin
        cmd_op   <= cur.op;
        cmd_arg  <= cur.arg;
        vol_mask <= cur.op[3:0];
        vol_lvl  <= cur.arg[4:0];
        phr_chan <= cur.op[3:2];
        phr_idx  <= {cur.op[1:0], cur.arg};
        ld_data  <= cur.op[0] ? {{(BYTE_W-1){1'b0}}, err} : stat_i;
      end
    end
  end

  p_err_dup_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(dup_q));
  p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> (cmd_stb && cmd_op[7:4] == NIB_CLR));
  p_strb_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pdwn_stb, vol_stb, phr_stb, ld}));
  p_dec_stb_r3: assert property (@(posedge clk) disable iff (rst)
    (pdwn_stb || vol_stb || phr_stb || ld) |-> cmd_stb);
endmodule

// File: rtl/dupcmd_slave.sv
module dupcmd_slave
  import dcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYC    = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        sdi,
  input  logic        edge_sel,
  input  logic [7:0]  stat_i,
  output logic        sdo,
  output logic        busy_n,
  output logic        err,
  output logic        cmd_stb,
  output logic [7:0]  cmd_op,
  output logic [7:0]  cmd_arg,
  output logic        pdwn_stb,
  output logic        vol_stb,
  output logic [3:0]  vol_mask,
  output logic [4:0]  vol_lvl,
  output logic        phr_stb,
  output logic [1:0]  phr_chan,
  output logic [9:0]  phr_idx
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic              smp_ev, drv_ev, sdi_s, cs_act;
  logic              byte_vld, ld;
  logic [BYTE_W-1:0] byte_q, ld_data;
  logic [BW-1:0]     busy_cnt;

  dcs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .edge_sel(edge_sel), .smp_ev(smp_ev), .drv_ev(drv_ev),
    .sdi_s(sdi_s), .cs_act(cs_act)
  );

  dcs_shift u_shift (
    .clk(clk), .rst(rst), .smp_ev(smp_ev), .drv_ev(drv_ev),
    .sdi_s(sdi_s), .cs_act(cs_act), .hold(!busy_n), .ld(ld),
    .ld_data(ld_data), .byte_vld(byte_vld), .byte_q(byte_q), .sdo(sdo)
  );

  dcs_frame u_frame (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_q(byte_q),
    .stat_i(stat_i), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .pdwn_stb(pdwn_stb), .vol_stb(vol_stb),
    .vol_mask(vol_mask), .vol_lvl(vol_lvl), .phr_stb(phr_stb),
    .phr_chan(phr_chan), .phr_idx(phr_idx), .ld(ld),
    .ld_data(ld_data), .err(err)
  );

  // busy window after every accepted byte
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      busy_n   <= 1'b1;
    end else begin
      if (byte_vld)             busy_cnt <= BW'(BUSY_CYC);
      else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
      busy_n <= !(byte_vld || busy_cnt > BW'(1));
    end
  end

  p_byte_busy_r11: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !busy_n);
  p_busy_cmd_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> !busy_n);
endmodule

// File: tb/dupcmd_slave_bench.sv
module dupcmd_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 0, rst = 1, cs_n = 1, sck = 1, sdi = 0, edge_sel = 1;
  logic [7:0] stat_i = 8'hC5;
  logic sdo, busy_n, err, cmd_stb, pdwn_stb, vol_stb, phr_stb;
  logic [7:0] cmd_op, cmd_arg;
  logic [3:0] vol_mask;
  logic [4:0] vol_lvl;
  logic [1:0] phr_chan;
  logic [9:0] phr_idx;

  int n_chk = 0, n_fail = 0, n_stb = 0;
  logic [7:0] l_op, l_arg;
  logic l_pd, l_vol, l_phr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dupcmd_slave u_dupcmd_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .edge_sel(edge_sel), .stat_i(stat_i), .sdo(sdo), .busy_n(busy_n),
    .err(err), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .pdwn_stb(pdwn_stb), .vol_stb(vol_stb), .vol_mask(vol_mask),
    .vol_lvl(vol_lvl), .phr_stb(phr_stb), .phr_chan(phr_chan),
    .phr_idx(phr_idx)
  );

  always @(negedge clk) begin
    if (!rst && cmd_stb) begin
      n_stb++;
      l_op = cmd_op; l_arg = cmd_arg;
      l_pd = pdwn_stb; l_vol = vol_stb; l_phr = phr_stb;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      tick(HALF); sck = ~edge_sel;
      tick(HALF); sck = edge_sel;
    end
  endtask

  task automatic wait_idle();
    tick(3);
    while (!busy_n) tick(1);
    tick(2);
  endtask

  task automatic send1(input logic [7:0] op);
    send_byte(op); wait_idle();
  endtask

  task automatic send2(input logic [7:0] op, input logic [7:0] arg);
    send_byte(op); wait_idle(); send_byte(arg); wait_idle();
  endtask

  task automatic read_byte(output logic [7:0] v);
    sdi = 0;
    tick(HALF);
    for (int i = 7; i >= 0; i--) begin
      v[i] = sdo;
      sck = ~edge_sel; tick(HALF);
      sck = edge_sel;  tick(HALF);
    end
  endtask

  function automatic bit two_b(input logic [3:0] h);
    return h inside {4'h0, 4'h1, 4'h3, 4'h5, 4'h7, 4'hA, 4'hD};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] rd, ea;
    tick(10);
    // R13 reset state
    chk(err == 0 && busy_n == 1 && sdo == 0 && n_stb == 0, "R13",
        {err, busy_n, sdo, 8'(n_stb)}, 32'h200);
    rst = 0;
    tick(10);
    cs_n = 0; tick(8);

    // exhaustive opcode sweep, duplicate mode off
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if (op == 128) begin
        cs_n = 1; tick(8); edge_sel = 0; sck = 0; tick(8); cs_n = 0; tick(8);
      end
      base = n_stb;
      ea = two_b(o[7:4]) ? ((o ^ 8'h5A) & 8'hFE) : 8'h00;
      if (two_b(o[7:4])) send2(o, ea); else send1(o);
      chk(n_stb - base == 1, "R2", 32'(n_stb - base), 1);
      chk(l_op == o && l_arg == ea, "R3", {l_op, l_arg}, {o, ea});
      chk(l_pd == (o == 8'h20), "R4", l_pd, (o == 8'h20));
      chk(l_vol == (o[7:4] == 4'hA) &&
          (o[7:4] != 4'hA || (vol_mask == o[3:0] && vol_lvl == ea[4:0])),
          "R5", {l_vol, vol_mask, vol_lvl}, {(o[7:4] == 4'hA), o[3:0], ea[4:0]});
      chk(l_phr == (o[7:4] == 4'h3) &&
          (o[7:4] != 4'h3 || (phr_chan == o[3:2] && phr_idx == {o[1:0], ea})),
          "R6", {l_phr, phr_chan, phr_idx}, {(o[7:4] == 4'h3), o[3:2], o[1:0], ea});
      if (o[7:4] == 4'hB) begin
        read_byte(rd);
        // R1 covered when edge_sel is 0, R7 otherwise
        chk(rd == (o[0] ? 8'h00 : 8'hC5), edge_sel ? "R7" : "R1",
            rd, (o[0] ? 8'h00 : 8'hC5));
      end
    end

    // duplicate mode
    base = n_stb;
    send2(8'h00, 8'h01);
    chk(n_stb - base == 1, "R8", 32'(n_stb - base), 1);
    base = n_stb;
    send2(8'hA3, 8'h11);
    chk(n_stb == base, "R8", 32'(n_stb - base), 0);
    send2(8'hA3, 8'h11);
    chk(n_stb - base == 1 && l_op == 8'hA3 && vol_lvl == 5'h11 && vol_mask == 4'h3,
        "R8", {8'(n_stb - base), l_op, 3'b0, vol_lvl}, {8'd1, 8'hA3, 8'h11});
    base = n_stb;
    send2(8'hA3, 8'h11); send2(8'hA3, 8'h12);
    chk(n_stb == base && err == 1, "R9", {8'(n_stb - base), 7'b0, err}, 32'h1);
    send1(8'h40); send1(8'h40);
    chk(n_stb - base == 1 && err == 1, "R9", {8'(n_stb - base), 7'b0, err}, 32'h101);
    send1(8'hB1); send1(8'hB1);
    read_byte(rd);
    chk(rd == 8'h01, "R7", rd, 8'h01);
    base = n_stb;
    send1(8'h80);
    chk(n_stb - base == 1 && err == 0, "R10", {8'(n_stb - base), 7'b0, err}, 32'h100);
    base = n_stb;
    send1(8'h45); send1(8'h80); send1(8'h45);
    chk(n_stb - base == 1 && l_op == 8'h80, "R10", {8'(n_stb - base), l_op}, 32'h180);
    send1(8'h45);
    chk(n_stb - base == 2 && l_op == 8'h45, "R10", {8'(n_stb - base), l_op}, 32'h245);
    send1(8'h46); send1(8'h47);
    chk(err == 1, "R9", err, 1);
    base = n_stb;
    send1(8'h80); send1(8'h80);
    chk(n_stb - base == 2 && err == 0, "R10", {8'(n_stb - base), 7'b0, err}, 32'h200);
    send2(8'h00, 8'h00); send2(8'h00, 8'h00);
    base = n_stb;
    send1(8'h48);
    chk(n_stb - base == 1 && l_op == 8'h48, "R8", {8'(n_stb - base), l_op}, 32'h148);

    // R11: a bit clocked during busy is dropped
    base = n_stb;
    send_byte(8'h40);
    sdi = 1; tick(HALF); sck = ~edge_sel; tick(HALF); sck = edge_sel;
    wait_idle();
    send1(8'h41);
    chk(n_stb - base == 2 && l_op == 8'h41, "R11", {8'(n_stb - base), l_op}, 32'h241);

    // R12: partial byte discarded on chip-select release
    base = n_stb;
    for (int i = 0; i < 3; i++) begin
      sdi = 1; tick(HALF); sck = ~edge_sel; tick(HALF); sck = edge_sel;
    end
    tick(HALF); cs_n = 1; tick(8); cs_n = 0; tick(8);
    send1(8'h42);
    chk(n_stb - base == 1 && l_op == 8'h42, "R12", {8'(n_stb - base), l_op}, 32'h142);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule